// File: doc/BRIEF.md
# Processor Tick Timer with Period Compare

This block is a per-core tick timer. It holds a 32-bit count register and a 32-bit mode register, both reached through a small register port. Software selects a register, then reads it or writes it in a single cycle. The count advances once per clock in the running modes. Its low 28 bits are compared against a programmed period, and a match raises a sticky pending flag. The interrupt output is that flag qualified by an enable bit.

In continuous mode the counter never stops or wraps early on a match. This lets it act as a monotonic time base while also producing one-shot events. Software arms the next event by reading the count, adding a delta and keeping the low 28 bits of the sum as the period. It acknowledges an event by rewriting the mode register with only the mode bits set. A capability register tells software that the timer exists.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the mode register reads 0 (disabled, enable 0, pending 0, period 0), and `irq_o` is 0.
- R2: In continuous mode (mode field 2'b11) the count increases by exactly 1 per clock across all 32 bits, and keeps increasing through a match.
- R3: A match happens when count[27:0] equals the period field, whatever count[31:28] holds, in any mode other than disabled.
- R4: A match sets the pending bit (mode register bit 28) on the next clock edge, even with the enable bit at 0. The bit then stays set until the mode register is written.
- R5: `irq_o` is high exactly while pending and the enable bit (mode register bit 29) are both 1, so it rises one clock after the matching cycle.
- R6: A mode-register write replaces every field: mode [31:30] (00 disabled, 01 restart, 10 stop, 11 continuous), enable [29], pending [28] and period [27:0]. Writing 32'hC000_0000 clears pending and enable and drops `irq_o`, while the count keeps running.
- R7: A count-register write replaces the count and takes priority over the increment, restart or hold of that cycle. A mode-register write takes priority over a match setting pending in the same cycle.
- R8: In restart mode (01) the count becomes 0 on the clock edge after the matching cycle, then counts up again.
- R9: In stop mode (10) the count holds its value from the matching cycle onward.
- R10: In disabled mode (00) the count does not change, and an equal period does not set pending.
- R11: Select codes are 0 for count, 1 for mode, 2 for capability and 3 unused. The capability register reads 32'h0000_0001 (bit 0 = timer present). Code 3 reads 0. Writes to codes 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 count, 1 mode, 2 capability, 3 unused |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt: pending AND enable |

## Verification
The assertions assume that `reg_sel` and `reg_we` are stable, known values at every rising edge, and that software never changes the count and the mode in the same cycle, since the port only allows one write per clock. The stimulus changes the port only on falling edges, issues at most one write per cycle, and inserts idle cycles so that each match lands on a cycle worked out in advance. The bench samples results one delay after the falling edge. At that point the design shows the state left by the previous rising edge.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int CNT_W  = 32;
  localparam int PER_W  = 28;
  localparam logic [CNT_W-1:0] CAP_WORD = 32'h0000_0001;

  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_STOP    = 2'b10,
    TM_CONT    = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_CAP   = 2'd2,
    SEL_NONE  = 2'd3
  } rsel_e;

  typedef struct packed {
    tmode_e            mode;
    logic              ie;
    logic              pend;
    logic [PER_W-1:0]  period;
  } tmr_mode_t;

  // Low-bits compare of count against the period field.
  function automatic logic period_hit(input logic [CNT_W-1:0] cnt,
                                      input logic [PER_W-1:0] per);
    return cnt[PER_W-1:0] == per;
  endfunction

  // Pending flag after one clock, absent a register write.
  function automatic logic pend_next(input logic pend, input logic hit);
    return pend | hit;
  endfunction
endpackage

// File: rtl/tick_count.sv
module tick_count
  import tick_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we,
  input  logic [W-1:0] wdata,
  input  tmode_e       mode,
  input  logic         hit,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we) begin
      cnt_d = wdata;
    end else begin
      unique case (mode)
        TM_OFF:     cnt_d = cnt_q;
        TM_RESTART: cnt_d = hit ? '0 : cnt_q + ONE;
        TM_STOP:    cnt_d = hit ? cnt_q : cnt_q + ONE;
        TM_CONT:    cnt_d = cnt_q + ONE;
        default:    cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cont_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && mode == TM_CONT) |=> cnt_q == $past(cnt_q) + ONE);
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wdata));
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && mode == TM_RESTART && hit) |=> cnt_q == '0);
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && mode == TM_STOP && hit) |=> $stable(cnt_q));
  assert_off_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && mode == TM_OFF) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_mode.sv
module tick_mode
  import tick_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [31:0] wdata,
  input  logic        hit,
  output tmr_mode_t   mode_q
);
  tmr_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d = tmr_mode_t'(wdata);
    end else begin
      mode_d.pend = pend_next(mode_q.pend, hit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assert_pend_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode_we) |=> mode_q.pend);
  assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.pend && !mode_we) |=> mode_q.pend);
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && wdata == 32'hC000_0000) |=> (!mode_q.pend && !mode_q.ie));
endmodule

// File: rtl/tick_readmux.sv
module tick_readmux
  import tick_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  rsel_e        sel,
  input  logic [W-1:0] cnt,
  input  tmr_mode_t    mode,
  output logic [W-1:0] rdata
);
  always_comb begin
    unique case (sel)
      SEL_COUNT: rdata = cnt;
      SEL_MODE:  rdata = W'(mode);
      SEL_CAP:   rdata = W'(CAP_WORD);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  rsel_e      sel;
  logic       cnt_we;
  logic       mode_we;
  logic       hit;
  logic [CNT_W-1:0] cnt_q;
  tmr_mode_t  mode_q;

  assign sel     = rsel_e'(reg_sel);
  assign cnt_we  = reg_we && (sel == SEL_COUNT);
  assign mode_we = reg_we && (sel == SEL_MODE);
  assign hit     = (mode_q.mode != TM_OFF) && period_hit(cnt_q, mode_q.period);

  tick_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .wdata(reg_wdata),
    .mode(mode_q.mode), .hit(hit), .cnt_q(cnt_q)
  );

  tick_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .wdata(reg_wdata),
    .hit(hit), .mode_q(mode_q)
  );

  tick_readmux #(.W(CNT_W)) u_rd (
    .sel(sel), .cnt(cnt_q), .mode(mode_q), .rdata(reg_rdata)
  );

  assign irq_o = mode_q.pend & mode_q.ie;

  assert_irq_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q.ie && !mode_we) |=> irq_o);
  assert_irq_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.pend) |-> !irq_o);
  assert_cap_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CAP) |-> reg_rdata == 32'h0000_0001);
  assert_hi_bits_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.mode != TM_OFF && !reg_we && cnt_q[27:0] == mode_q.period) |=> mode_q.pend);
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Mode word: {mode[1:0], ie, pend, period[27:0]}
  function automatic logic [31:0] mword(input logic [1:0] m, input bit ie,
                                        input bit pd, input logic [27:0] per);
    return {m, ie, pd, per};
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
  endtask

  task automatic chk(input logic [1:0] s, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_sel = s; reg_we = 1'b0; reg_wdata = '0;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t it;
    @(negedge clk);
    reg_we = 1'b0;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_we = 1'b0;
    end
  endtask

  // Monitor: compares queued expectations after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
        n_vec++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(2'd0, 32'h0, "R1 count");
    chk(2'd1, 32'h0, "R1 mode");
    chk_irq(1'b0, "R1 irq");

    // R10 disabled: no increment, equal period sets nothing; R7 load
    wr(2'd0, 32'd100);
    chk(2'd0, 32'd100, "R7 load");
    chk(2'd0, 32'd100, "R10 hold");
    wr(2'd1, mword(2'b00, 1'b0, 1'b0, 28'd100));
    idle(2);
    chk(2'd1, mword(2'b00, 1'b0, 1'b0, 28'd100), "R10 no pend");
    chk(2'd0, 32'd100, "R10 still held");

    // R2/R3/R4 continuous with upper count bits set
    wr(2'd0, 32'hA000_0000);
    wr(2'd1, mword(2'b11, 1'b0, 1'b0, 28'h10));
    chk(2'd0, 32'hA000_0000, "R2 start");
    chk(2'd0, 32'hA000_0001, "R2 step");
    idle(14);
    chk(2'd1, mword(2'b11, 1'b0, 1'b0, 28'h10), "R3 before match");
    chk(2'd1, mword(2'b11, 1'b0, 1'b1, 28'h10), "R3 R4 pend set");
    chk_irq(1'b0, "R4 irq gated");
    chk(2'd0, 32'hA000_0013, "R2 past match");

    // R6 acknowledge by writing mode bits only
    wr(2'd1, 32'hC000_0000);
    chk(2'd1, 32'hC000_0000, "R6 cleared");
    chk(2'd0, 32'hA000_0016, "R6 running");
    chk_irq(1'b0, "R6 irq low");

    // R5 interrupt with enable
    wr(2'd0, 32'd5);
    wr(2'd1, mword(2'b11, 1'b1, 1'b0, 28'd8));
    idle(2);
    chk_irq(1'b0, "R5 match cycle");
    chk_irq(1'b1, "R5 irq rises");
    chk(2'd1, mword(2'b11, 1'b1, 1'b1, 28'd8), "R5 mode");
    wr(2'd1, 32'hC000_0000);
    chk_irq(1'b0, "R6 irq dropped");

    // R8 restart; mode write beats a same-cycle match (R7)
    wr(2'd0, 32'd0);
    wr(2'd1, mword(2'b01, 1'b0, 1'b0, 28'd3));
    chk(2'd0, 32'd1, "R8 count");
    idle(1);
    chk(2'd0, 32'd3, "R8 at match");
    chk(2'd0, 32'd0, "R8 restarted");
    chk(2'd0, 32'd1, "R8 counting");
    chk(2'd1, mword(2'b01, 1'b0, 1'b1, 28'd3), "R8 pend");

    // R9 stop
    wr(2'd0, 32'd0);
    wr(2'd1, mword(2'b10, 1'b0, 1'b0, 28'd2));
    chk(2'd0, 32'd1, "R9 count");
    chk(2'd0, 32'd2, "R9 at match");
    chk(2'd0, 32'd2, "R9 held");
    chk(2'd0, 32'd2, "R9 still held");
    chk(2'd1, mword(2'b10, 1'b0, 1'b1, 28'd2), "R9 pend");

    // R7 load beats the increment while running
    wr(2'd1, 32'hC000_0000);
    wr(2'd0, 32'h50);
    chk(2'd0, 32'h50, "R7 load wins");
    chk(2'd0, 32'h51, "R7 then counts");

    // R11 capability, unused code, ignored writes
    wr(2'd2, 32'h0);
    chk(2'd2, 32'h1, "R11 cap");
    wr(2'd3, 32'hFFFF_FFFF);
    chk(2'd3, 32'h0, "R11 unused");
    chk(2'd1, 32'hC000_0000, "R11 mode untouched");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule